// File: doc/BRIEF.md
# Multi-Address Cell Ingress Port

This block is the receiving end of a byte-wide cell transfer link in which an ATM-layer master pushes fixed 53-byte cells to one of several physical-layer ports that share a bus. The master drives a byte bus, an active-low byte enable and an active-high start-of-cell flag. The port frames cells on the start-of-cell flag and writes every accepted byte into a small cell store through a write port. It pulses a completion strobe on the final byte of each cell. Any byte that arrives while no cell is open is thrown away.

Before sending, the master polls ports by placing a 5-bit address on a poll bus. In the cycle after the port sees its own configured address, it drives a cell-available flag that says whether it can take one more whole cell. In every other cycle it floats that flag. The floating pin is modelled as a value output plus an output enable. Occupancy of the store is counted in whole cells. A downstream consumer returns slots with a one-cycle free pulse.

Top module: `cell_ingress_port`

## Requirements
- R1: After reset, `wr_en`, `cell_done` and `clav_oe` are all low, the store is empty, and no cell is open.
- R2: A byte is accepted only on a rising edge where `cell_enb_n` is low. An accepted byte appears on `wr_data` with `wr_en` high after that same edge, one cycle of latency.
- R3: An accepted byte with `cell_soc` high opens a cell and is written at byte index 0. `wr_addr` is `{slot, index}`: the upper bit is the slot and the low 6 bits are the byte index 0..52.
- R4: The 53rd accepted byte of a cell is written at index 52 with `cell_done` high for exactly that cycle. The cell then closes and the slot advances modulo 2.
- R5: Accepted bytes with `cell_soc` low are not written while no cell is open.
- R6: A start-of-cell accepted while a cell is open discards the partial cell. The new byte is written at index 0 of the same slot.
- R7: `clav_oe` is high in a cycle if and only if `poll_addr` equalled `own_addr` at the previous rising edge.
- R8: While `clav_oe` is high, `clav_val` is 1 when (completed cells held + 1 if a cell is open) is below 2, evaluated at that edge, and 0 otherwise.
- R9: A start-of-cell that arrives while the store holds 2 completed cells is not written, and the bytes after it are not written either.
- R10: A `cell_free` pulse lowers the held-cell count by one. It has no effect when the count is zero. When it coincides with a cell completion, the count is unchanged.
- R11: `cell_soc` high on an edge where `cell_enb_n` is high neither opens a cell nor writes a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 5 | Poll address this port answers to |
| poll_addr | input | 5 | Poll address driven by the master, bit 4 MSB |
| cell_byte | input | 8 | Incoming cell byte, bit 7 MSB |
| cell_soc | input | 1 | Start-of-cell flag, active high |
| cell_enb_n | input | 1 | Byte enable, active low |
| cell_free | input | 1 | Consumer returns one stored cell |
| clav_val | output | 1 | Cell-available value when driven |
| clav_oe | output | 1 | Output enable of the cell-available pin |
| wr_en | output | 1 | Store write strobe |
| wr_addr | output | 7 | Store write address {slot, byte index} |
| wr_data | output | 8 | Store write data |
| cell_done | output | 1 | Pulse on the final byte of a cell |

## Verification
Two functions can fall in the same cycle. The first is the completion of a cell, which adds one to the held count. The second is a consumer free, which removes one from that count. The bench forces the two together by raising `cell_free` on the edge that carries byte 53. It judges the result by polling the port afterwards and checking `clav_val`, and by filling the store again to see that the third start-of-cell is refused only when the count is really 2. Random stimulus also makes polls land on completion edges and on restarts, and a bench reference model tracks the count to predict each answer.

// File: rtl/cip_pkg.sv
package cip_pkg;
    localparam int BYTE_W     = 8;
    localparam int PADDR_W    = 5;
    localparam int CELL_BYTES = 53;
    localparam int IDX_W      = $clog2(CELL_BYTES);

    typedef enum logic {PH_HUNT = 1'b0, PH_CELL = 1'b1} phase_t;
endpackage

// File: rtl/cip_poll_resp.sv
module cip_poll_resp #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] poll_addr,
    input  logic              room,
    output logic              clav_val,
    output logic              clav_oe
);
    typedef struct packed {
        logic oe;
        logic val;
    } poll_t;

    poll_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.oe  = (poll_addr == own_addr);
        st_d.val = st_d.oe && room;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clav_oe  = st_q.oe;
    assign clav_val = st_q.val;

    // R7: the pin floats whenever the previous poll named another port
    a_r7_float_other: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_addr != own_addr) |=> !clav_oe);
    a_r7_drive_own: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_addr == own_addr) |=> clav_oe);
endmodule

// File: rtl/cip_occupancy.sv
module cip_occupancy #(
    parameter int BUF_CELLS = 2,
    localparam int OCC_W = $clog2(BUF_CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_in,
    input  logic             cell_out,
    output logic [OCC_W-1:0] held,
    output logic             full
);
    logic [OCC_W-1:0] held_d, held_q;
    logic             take;

    always_comb begin
        take   = cell_out && (held_q != '0);
        held_d = held_q;
        if (cell_in && !take)      held_d = held_q + OCC_W'(1);
        else if (!cell_in && take) held_d = held_q - OCC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign held = held_q;
    assign full = (held_q == OCC_W'(BUF_CELLS));

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= OCC_W'(BUF_CELLS));
    a_r9_full_no_complete: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !cell_in);
    a_r10_empty_free_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == '0 && cell_out && !cell_in) |=> held_q == '0);
endmodule

// File: rtl/cip_framer.sv
module cip_framer
    import cip_pkg::*;
#(
    parameter int BUF_CELLS = 2,
    localparam int SLOT_W = (BUF_CELLS > 1) ? $clog2(BUF_CELLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              soc,
    input  logic              enb_n,
    input  logic              room_for_soc,
    output logic              in_cell,
    output logic              done_now,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              cell_done
);
    typedef struct packed {
        phase_t            phase;
        logic [IDX_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic              we;
        logic [SLOT_W-1:0] we_slot;
        logic [IDX_W-1:0]  we_idx;
        logic [BYTE_W-1:0] we_data;
        logic              done;
    } fr_t;

    fr_t st_d, st_q;
    logic take;

    always_comb begin
        take         = !enb_n;
        st_d         = st_q;
        st_d.we      = 1'b0;
        st_d.done    = 1'b0;
        st_d.we_data = byte_in;
        if (take && soc) begin
            if (room_for_soc) begin
                st_d.phase   = PH_CELL;
                st_d.we      = 1'b1;
                st_d.we_slot = st_q.slot;
                st_d.we_idx  = '0;
                st_d.cnt     = IDX_W'(1);
            end else begin
                st_d.phase = PH_HUNT;
                st_d.cnt   = '0;
            end
        end else if (take && st_q.phase == PH_CELL) begin
            st_d.we      = 1'b1;
            st_d.we_slot = st_q.slot;
            st_d.we_idx  = st_q.cnt;
            if (st_q.cnt == IDX_W'(CELL_BYTES - 1)) begin
                st_d.done  = 1'b1;
                st_d.phase = PH_HUNT;
                st_d.cnt   = '0;
                st_d.slot  = (st_q.slot == SLOT_W'(BUF_CELLS - 1)) ? '0
                                                                  : st_q.slot + SLOT_W'(1);
            end else begin
                st_d.cnt = st_q.cnt + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_cell   = (st_q.phase == PH_CELL);
    assign done_now  = st_d.done;
    assign wr_en     = st_q.we;
    assign wr_slot   = st_q.we_slot;
    assign wr_idx    = st_q.we_idx;
    assign wr_data   = st_q.we_data;
    assign cell_done = st_q.done;

    a_r4_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        cell_done |-> (wr_en && wr_idx == IDX_W'(CELL_BYTES - 1)));
    a_r2_idle_enable: assert property (@(posedge clk) disable iff (!rst_n)
        enb_n |=> !wr_en);
    a_r3_soc_index0: assert property (@(posedge clk) disable iff (!rst_n)
        (!enb_n && soc && room_for_soc) |=> (wr_en && wr_idx == '0));
    a_r5_hunt_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cell && !soc) |=> !wr_en);
endmodule

// File: rtl/cell_ingress_port.sv
module cell_ingress_port
    import cip_pkg::*;
#(
    parameter int BUF_CELLS = 2,
    localparam int SLOT_W = (BUF_CELLS > 1) ? $clog2(BUF_CELLS) : 1,
    localparam int OCC_W  = $clog2(BUF_CELLS + 1),
    localparam int PEND_W = OCC_W + 1,
    localparam int WA_W   = SLOT_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PADDR_W-1:0] own_addr,
    input  logic [PADDR_W-1:0] poll_addr,
    input  logic [BYTE_W-1:0]  cell_byte,
    input  logic               cell_soc,
    input  logic               cell_enb_n,
    input  logic               cell_free,
    output logic               clav_val,
    output logic               clav_oe,
    output logic               wr_en,
    output logic [WA_W-1:0]    wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               cell_done
);
    logic              in_cell, done_now, full;
    logic [OCC_W-1:0]  held;
    logic [PEND_W-1:0] pending;
    logic [SLOT_W-1:0] wr_slot;
    logic [IDX_W-1:0]  wr_idx;
    logic              room;

    assign pending = {1'b0, held} + {{OCC_W{1'b0}}, in_cell};
    assign room    = pending < PEND_W'(BUF_CELLS);
    assign wr_addr = {wr_slot, wr_idx};

    cip_framer #(.BUF_CELLS(BUF_CELLS)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_in      (cell_byte),
        .soc          (cell_soc),
        .enb_n        (cell_enb_n),
        .room_for_soc (!full),
        .in_cell      (in_cell),
        .done_now     (done_now),
        .wr_en        (wr_en),
        .wr_slot      (wr_slot),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .cell_done    (cell_done)
    );

    cip_occupancy #(.BUF_CELLS(BUF_CELLS)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_in  (done_now),
        .cell_out (cell_free),
        .held     (held),
        .full     (full)
    );

    cip_poll_resp #(.ADDR_W(PADDR_W)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_addr  (own_addr),
        .poll_addr (poll_addr),
        .room      (room),
        .clav_val  (clav_val),
        .clav_oe   (clav_oe)
    );

    // R8: a driven flag reporting room implies the store was not full at the poll edge
    a_r8_clav_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> !(clav_oe && clav_val));
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cell_done |=> !cell_done);
endmodule

// File: tb/cell_ingress_port_tb.sv
module cell_ingress_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] OWN = 5'h0B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] poll_addr = 5'h00;
    logic [7:0] cell_byte = 8'h00;
    logic       cell_soc = 1'b0;
    logic       cell_enb_n = 1'b1;
    logic       cell_free = 1'b0;
    logic       clav_val, clav_oe, wr_en, cell_done;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;

    int vectors = 0;
    int errors = 0;
    bit ended = 0;

    // reference model state
    bit       m_in;
    int       m_cnt, m_occ;
    bit       m_slot;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_ingress_port u_dut (
        .clk(clk), .rst_n(rst_n), .own_addr(OWN), .poll_addr(poll_addr),
        .cell_byte(cell_byte), .cell_soc(cell_soc), .cell_enb_n(cell_enb_n),
        .cell_free(cell_free), .clav_val(clav_val), .clav_oe(clav_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cell_done(cell_done)
    );

    task automatic check(input string tag, input string what, input logic [31:0] got,
                         input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic bit exp_room(input int occ, input bit in_c);
        return (occ + (in_c ? 1 : 0)) < 2;
    endfunction

    task automatic step(input logic [7:0] d, input bit s, input bit en_n,
                        input logic [4:0] pa, input bit fr, input string tag);
        bit e_wr, e_done, e_oe, e_clav, dn;
        logic [6:0] e_addr;
        int prev_occ;
        cell_byte = d; cell_soc = s; cell_enb_n = en_n; poll_addr = pa; cell_free = fr;
        e_oe = (pa == OWN);
        e_clav = exp_room(m_occ, m_in);
        e_wr = 0; e_done = 0; dn = 0; e_addr = '0;
        prev_occ = m_occ;
        if (!en_n && s) begin
            if (m_occ < 2) begin
                e_wr = 1; e_addr = {m_slot, 6'd0}; m_in = 1; m_cnt = 1;
            end else begin
                m_in = 0; m_cnt = 0;
            end
        end else if (!en_n && m_in) begin
            e_wr = 1; e_addr = {m_slot, 6'(m_cnt)};
            if (m_cnt == 52) begin
                e_done = 1; dn = 1; m_in = 0; m_cnt = 0; m_slot = ~m_slot;
            end else m_cnt++;
        end
        m_occ = prev_occ + (dn ? 1 : 0) - ((fr && prev_occ != 0) ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        check(tag, "wr_en (R2)", 32'(wr_en), 32'(e_wr));
        check(tag, "cell_done (R4)", 32'(cell_done), 32'(e_done));
        check(tag, "clav_oe (R7)", 32'(clav_oe), 32'(e_oe));
        if (e_oe) check(tag, "clav_val (R8)", 32'(clav_val), 32'(e_clav));
        if (e_wr) begin
            check(tag, "wr_addr (R3)", 32'(wr_addr), 32'(e_addr));
            check(tag, "wr_data (R2)", 32'(wr_data), 32'(d));
        end
    endtask

    task automatic send_cell(input bit free_last, input string tag);
        step(8'hA0, 1, 0, 5'h1F, 0, tag);
        for (int i = 1; i < 53; i++) begin
            if (i % 9 == 0) step(8'hEE, 0, 1, 5'h1F, 0, tag);
            step(8'(i * 3), 0, 0, 5'h1F, (i == 52) && free_last, tag);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        m_in = 0; m_cnt = 0; m_occ = 0; m_slot = 0;
        void'($urandom(32'h5EED_0C11));
        repeat (3) @(negedge clk);
        check("R1", "wr_en", 32'(wr_en), 0);
        check("R1", "cell_done", 32'(cell_done), 0);
        check("R1", "clav_oe", 32'(clav_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7/R8: poll another port, then this port
        step(8'h00, 0, 1, 5'h0A, 0, "R7");
        step(8'h00, 0, 1, OWN, 0, "R7");
        step(8'h00, 0, 1, 5'h1F, 0, "R7");
        // R5: stray bytes with no cell open
        for (int i = 0; i < 4; i++) step(8'h55, 0, 0, 5'h1F, 0, "R5");
        // R11: soc without enable, then an enabled plain byte
        step(8'h77, 1, 1, 5'h1F, 0, "R11");
        step(8'h78, 0, 0, 5'h1F, 0, "R11");
        // R4: a full cell with enable gaps
        send_cell(0, "R4");
        step(8'h00, 0, 1, OWN, 0, "R8");
        // R6: partial cell then restart
        step(8'hC0, 1, 0, 5'h1F, 0, "R6");
        for (int i = 0; i < 20; i++) step(8'(i), 0, 0, 5'h1F, 0, "R6");
        step(8'h00, 0, 1, OWN, 0, "R8");
        send_cell(0, "R6");
        step(8'h00, 0, 1, OWN, 0, "R8");
        // R9: store full, soc refused
        step(8'h99, 1, 0, OWN, 0, "R9");
        for (int i = 0; i < 5; i++) step(8'h98, 0, 0, 5'h1F, 0, "R9");
        // R10: free one, then complete while freeing
        step(8'h00, 0, 1, 5'h1F, 1, "R10");
        send_cell(1, "R10");
        step(8'h00, 0, 1, OWN, 0, "R10");
        // R10: drain past empty, then refill and confirm third soc refused
        for (int i = 0; i < 4; i++) step(8'h00, 0, 1, 5'h1F, 1, "R10");
        send_cell(0, "R10");
        send_cell(0, "R10");
        step(8'h00, 0, 1, OWN, 0, "R10");
        step(8'h44, 1, 0, 5'h1F, 0, "R9");
        step(8'h00, 0, 1, 5'h1F, 1, "R10");
        step(8'h00, 0, 1, 5'h1F, 1, "R10");
        // random traffic
        for (int n = 0; n < 6000; n++) begin
            logic [7:0] d = 8'($urandom);
            bit en_n = ($urandom % 10) < 3;
            bit s = ($urandom % 60) == 0;
            logic [4:0] pa = (($urandom % 4) == 0) ? OWN : 5'($urandom);
            bit fr = ($urandom % 40) == 0;
            step(d, s, en_n, pa, fr, "R2");
        end
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule